// File: doc/BRIEF.md
# Cache Way Predictor

This block is a small prediction table for a set-associative cache with 2^WAY_BITS ways that reads its tag array and its data array one after the other. On each lookup the cache presents the set index and the lowest few tag bits. The table returns, in the same cycle, the way whose data should be read first. The prediction is only a hint. The cache's full tag compare decides whether the access really hits, and reports the result one cycle later.

When the compare finds a hit in a way other than the predicted one, the block raises a misprediction flag. In that same cycle it rewrites the entry with the way that actually hit. When a miss is later resolved by a fill, the cache reports the set, the tag bits and the chosen victim way, and the entry learns that way. A correct hint costs one data-way read. A wrong hint costs an extra access, which the pipeline sees like a short miss.

Top module: `way_hint_table`

## Requirements
- R1: After reset every entry predicts way 0, so every lookup returns `hint_way` = 0 until that entry is written.
- R2: `hint_way` is the entry selected by the key {`lk_set`, `lk_tag_lo`} (set index in the upper bits). It is valid combinationally in the same cycle as the key.
- R3: Lookups with the same set index and different low tag bits use separate entries. Training one entry leaves the other unchanged.
- R4: In the cycle after a lookup with `lk_valid`=1, `mispredict` is 1 exactly when `cmp_hit`=1 and `cmp_way` differs from the way predicted for that lookup.
- R5: On a misprediction the entry of that lookup is rewritten with `cmp_way`. The next lookup of the same key returns it.
- R6: A correct prediction (`cmp_hit`=1 with a matching way) or a cache miss (`cmp_hit`=0) gives `mispredict`=0 and leaves the entry unchanged.
- R7: A fill (`fill_valid`=1) writes `fill_way` into the entry keyed by {`fill_set`, `fill_tag_lo`}. It is visible from the next cycle.
- R8: When a fill and a misprediction retrain the same entry in the same cycle, the fill's way is kept.
- R9: A lookup in the same cycle as a write to its entry returns the old value.
- R10: When `lk_valid` was 0 in the previous cycle, `mispredict` stays 0 whatever `cmp_hit` and `cmp_way` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_set | input | SET_BITS | Set index of the lookup |
| lk_tag_lo | input | KEY_TAG_BITS | Lowest tag bits of the lookup |
| hint_way | output | WAY_BITS | Predicted way for the current key |
| cmp_hit | input | 1 | Full tag compare hit, for the previous cycle's lookup |
| cmp_way | input | WAY_BITS | Way that hit in the full compare |
| mispredict | output | 1 | Hit in a way other than the one predicted |
| fill_valid | input | 1 | A replacement fill completes this cycle |
| fill_set | input | SET_BITS | Set index of the fill |
| fill_tag_lo | input | KEY_TAG_BITS | Lowest tag bits of the filled block |
| fill_way | input | WAY_BITS | Victim way that received the block |

## Verification
A corrupted table entry shows up in `hint_way` on the very next lookup of that key, with no delay, because the read is combinational. A wrong stage register shows up in `mispredict` one cycle after the lookup. If the table were keyed on the set alone, training one low-tag entry would change the hint of its neighbour at once. A lost or misordered write is exposed two cycles after the offending misprediction or fill, when the same key is looked up again.

// File: rtl/way_hint_table.sv
module way_hint_table #(
  parameter int WAY_BITS     = 2,
  parameter int SET_BITS     = 4,
  parameter int KEY_TAG_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [SET_BITS-1:0]     lk_set,
  input  logic [KEY_TAG_BITS-1:0] lk_tag_lo,
  output logic [WAY_BITS-1:0]     hint_way,
  input  logic                    cmp_hit,
  input  logic [WAY_BITS-1:0]     cmp_way,
  output logic                    mispredict,
  input  logic                    fill_valid,
  input  logic [SET_BITS-1:0]     fill_set,
  input  logic [KEY_TAG_BITS-1:0] fill_tag_lo,
  input  logic [WAY_BITS-1:0]     fill_way
);

  localparam int KEY_BITS = SET_BITS + KEY_TAG_BITS;
  localparam int ENTRIES  = 1 << KEY_BITS;

  logic [WAY_BITS-1:0] tbl [ENTRIES];
  logic [KEY_BITS-1:0] lk_key, fill_key, s1_key;
  logic [WAY_BITS-1:0] s1_pred;
  logic                s1_valid;

  assign lk_key   = {lk_set, lk_tag_lo};
  assign fill_key = {fill_set, fill_tag_lo};
  assign hint_way = tbl[lk_key];

  assign mispredict = s1_valid && cmp_hit && (cmp_way != s1_pred);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_key   <= '0;
      s1_pred  <= '0;
    end else begin
      s1_valid <= lk_valid;
      s1_key   <= lk_key;
      s1_pred  <= hint_way;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      if (mispredict) tbl[s1_key] <= cmp_way;
      if (fill_valid) tbl[fill_key] <= fill_way;
    end
  end

endmodule

module way_hint_table_chk #(
  parameter int WAY_BITS     = 2,
  parameter int SET_BITS     = 4,
  parameter int KEY_TAG_BITS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lk_valid,
  input logic [SET_BITS-1:0]     lk_set,
  input logic [KEY_TAG_BITS-1:0] lk_tag_lo,
  input logic [WAY_BITS-1:0]     hint_way,
  input logic                    cmp_hit,
  input logic [WAY_BITS-1:0]     cmp_way,
  input logic                    mispredict,
  input logic                    fill_valid,
  input logic [SET_BITS-1:0]     fill_set,
  input logic [KEY_TAG_BITS-1:0] fill_tag_lo,
  input logic [WAY_BITS-1:0]     fill_way
);

  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  a_r10_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    mispredict |-> $past(lk_valid));

  a_r6_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> cmp_hit);

  a_r4_way_differs: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    mispredict |-> (cmp_way != $past(hint_way)));

  a_r4_flags_wrong_hit: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(lk_valid) && cmp_hit && cmp_way != $past(hint_way)) |-> mispredict);

  a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (!({lk_set, lk_tag_lo} == $past({fill_set, fill_tag_lo}))
                    || hint_way == $past(fill_way)));

endmodule

bind way_hint_table way_hint_table_chk #(
  .WAY_BITS(WAY_BITS), .SET_BITS(SET_BITS), .KEY_TAG_BITS(KEY_TAG_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_set(lk_set),
  .lk_tag_lo(lk_tag_lo), .hint_way(hint_way), .cmp_hit(cmp_hit),
  .cmp_way(cmp_way), .mispredict(mispredict), .fill_valid(fill_valid),
  .fill_set(fill_set), .fill_tag_lo(fill_tag_lo), .fill_way(fill_way)
);

// File: tb/test_way_hint_table.sv
module test_way_hint_table;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       lk_valid = 0;
  logic [3:0] lk_set = 0;
  logic [1:0] lk_tag_lo = 0;
  logic [1:0] hint_way;
  logic       cmp_hit = 0;
  logic [1:0] cmp_way = 0;
  logic       mispredict;
  logic       fill_valid = 0;
  logic [3:0] fill_set = 0;
  logic [1:0] fill_tag_lo = 0;
  logic [1:0] fill_way = 0;

  int runs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  way_hint_table i_way_hint_table (.*);

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lookup in one cycle, compare result (and optional fill) in the next
  task automatic access(input logic [3:0] s, input logic [1:0] t, input int exp_hint,
                        input logic hit, input logic [1:0] w, input int exp_mis,
                        input logic fl, input logic [1:0] fw, input string req);
    @(negedge clk);
    lk_valid = 1; lk_set = s; lk_tag_lo = t;
    #1 chk({req, " hint"}, hint_way, exp_hint);
    @(negedge clk);
    lk_valid = 0; cmp_hit = hit; cmp_way = w;
    fill_valid = fl; fill_set = s; fill_tag_lo = t; fill_way = fw;
    #1 chk({req, " mispredict"}, mispredict, exp_mis);
    @(negedge clk);
    cmp_hit = 0; fill_valid = 0;
  endtask

  task automatic peek(input logic [3:0] s, input logic [1:0] t, input int exp, input string req);
    @(negedge clk);
    lk_valid = 0; lk_set = s; lk_tag_lo = t;
    #1 chk(req, hint_way, exp);
  endtask

  task automatic t_reset;
    peek(0, 0, 0, "R1"); peek(15, 3, 0, "R1"); peek(9, 2, 0, "R2");
    #1 chk("R1 mispredict", mispredict, 0);
  endtask

  task automatic t_retrain;
    access(3, 1, 0, 1, 2, 1, 0, 0, "R4");
    peek(3, 1, 2, "R5");
  endtask

  task automatic t_tagkey;
    peek(3, 2, 0, "R3");
    access(3, 2, 0, 1, 1, 1, 0, 0, "R3 train");
    peek(3, 1, 2, "R3 neighbour");
    peek(3, 2, 1, "R2");
  endtask

  task automatic t_correct;
    access(3, 1, 2, 1, 2, 0, 0, 0, "R6 correct");
    access(3, 1, 2, 0, 3, 0, 0, 0, "R6 miss");
    peek(3, 1, 2, "R6 unchanged");
  endtask

  task automatic t_fill;
    @(negedge clk);
    fill_valid = 1; fill_set = 5; fill_tag_lo = 0; fill_way = 3;
    @(negedge clk);
    fill_valid = 0;
    peek(5, 0, 3, "R7");
  endtask

  task automatic t_collision;
    access(6, 1, 0, 1, 1, 1, 1, 3, "R8");
    peek(6, 1, 3, "R8");
  endtask

  task automatic t_rdw;
    @(negedge clk);
    fill_valid = 1; fill_set = 7; fill_tag_lo = 3; fill_way = 1;
    lk_valid = 1; lk_set = 7; lk_tag_lo = 3;
    #1 chk("R9 old value", hint_way, 0);
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    #1 chk("R9 new value", hint_way, 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    lk_valid = 0; lk_set = 3; lk_tag_lo = 1;
    @(negedge clk);
    cmp_hit = 1; cmp_way = 3;
    #1 chk("R10", mispredict, 0);
    @(negedge clk);
    cmp_hit = 0;
    peek(3, 1, 2, "R10 unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_retrain;
    t_tagkey;
    t_correct;
    t_fill;
    t_collision;
    t_rdw;
    t_idle;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule